// File: doc/BRIEF.md
# Itemset Support Counting Cell

This cell is one stage of a linear systolic chain that measures the support of candidate itemsets over a transaction database. A candidate is an ascending list of up to `MAX_M` items, with its length `m` given on `candLen`. It is written into the cell by a restart word and then by load words. Once the cell holds `m` items, further load words pass on to the next cell. Transactions follow as ascending item words, each closed by an end-of-transaction word.

The cell tests whether its candidate is a subset of each transaction by a streaming merge. An index points at the next stored item still to be found, and every incoming item is compared once against that stored item. At each transaction end the support counter counts a full match, and the index and failure state clear for the next transaction. Every word except a stored load word is passed downstream through one register stage.

The counters are read out by a shift mode. While `shiftEn` is high, each cell takes the count of its upstream neighbour, so the counts leave the far end of the chain one per cycle.

Top module: `support_cell`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `supportOut` is 0 and `dnValid` is 0. No candidate items are stored and the match state is empty.
- R2: The word kind on `upKind` is encoded as 0 = transaction item, 1 = end of transaction, 2 = candidate load, 3 = restart. A restart word clears the support counter and the count of stored candidate items. From the cycle after it, `supportOut` reads 0.
- R3: While fewer than `candLen` items are stored, a load word is written into the next candidate slot in arrival order and is not forwarded (`dnValid` stays 0). After that, load words are forwarded.
- R4: Item, end-of-transaction and restart words, and load words that are not stored, appear on `dnValid`/`dnKind`/`dnData` unchanged one cycle after they are accepted. A cycle with no valid input leaves `dnValid` at 0 in the next cycle.
- R5: When an incoming item equals the stored item under the index, the index advances by one. When the stored item is greater, the index holds and the item is skipped.
- R6: When an incoming item is greater than the stored item under the index, while the index is below `m`, the transaction is marked failed. Later items in that transaction cannot revive it.
- R7: At an end-of-transaction word, the counter increments when the index equals `m` and the transaction is not failed. The new count shows on `supportOut` in the cycle after the end word. The index and the failure mark then clear.
- R8: Transaction item words never change `supportOut`. A single end word changes it by at most one.
- R9: The counter saturates. At its all-ones value, a further match leaves it unchanged.
- R10: While `shiftEn` is high, the counter loads `shiftIn` on the clock edge, taking precedence over any stream update. `supportOut` always shows the current count, so the chain shifts one cell per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| candLen | input | IDX_W | Candidate length m, 1 to MAX_M |
| upValid | input | 1 | Upstream word valid |
| upKind | input | 2 | Upstream word kind (0 item, 1 end, 2 load, 3 restart) |
| upData | input | ITEM_W | Upstream item value |
| shiftEn | input | 1 | Counter shift mode |
| shiftIn | input | CNT_W | Count from the upstream cell |
| dnValid | output | 1 | Downstream word valid |
| dnKind | output | 2 | Downstream word kind |
| dnData | output | ITEM_W | Downstream item value |
| supportOut | output | CNT_W | Current support count, also the shift output |

## Verification
The assertions check the following on every cycle:
- the forwarding of words one cycle later, and the idle gap;
- that item words never change the count;
- that an end word changes the count by at most one, and that the counter holds at all-ones;
- the shift load and the clear after a restart.

Whether a given transaction counts depends on the stored candidate and on the merge state. Only the bench's scenarios can show this: skipped smaller items, sticky failure after an overshoot, short transactions, empty transactions and a reloaded candidate of a different length. The bench also shows that load words are stored in order and that forwarding starts only once the candidate is full.

// File: rtl/support_pkg.sv
package support_pkg;

  typedef enum logic [1:0] {
    KIND_ITEM    = 2'd0,
    KIND_END     = 2'd1,
    KIND_LOAD    = 2'd2,
    KIND_RESTART = 2'd3
  } kind_e;

  typedef struct packed {
    logic candWr;
    logic incCount;
    logic clrCount;
    logic shift;
    logic fwd;
  } strobe_t;

endpackage

// File: rtl/support_ctl.sv
module support_ctl
  import support_pkg::*;
#(
  parameter int MAX_M  = 8,
  parameter int IDX_W  = $clog2(MAX_M + 1),
  parameter int ADDR_W = (MAX_M > 1) ? $clog2(MAX_M) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  candLen,
  input  logic              upValid,
  input  logic [1:0]        upKind,
  input  logic              shiftEn,
  input  logic              itemEq,
  input  logic              storedGt,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

  logic [IDX_W-1:0] fill;
  logic [IDX_W-1:0] idx;
  logic             fail;

  kind_e kind;
  logic  isItem, isEnd, isLoad, isRestart, candFull, searching;

  always_comb begin
    kind      = kind_e'(upKind);
    isItem    = upValid && (kind == KIND_ITEM);
    isEnd     = upValid && (kind == KIND_END);
    isLoad    = upValid && (kind == KIND_LOAD);
    isRestart = upValid && (kind == KIND_RESTART);
    candFull  = (fill >= candLen);
    searching = isItem && !fail && (idx < candLen);

    strobe.candWr   = isLoad && !candFull;
    strobe.fwd      = upValid && !(isLoad && !candFull);
    strobe.incCount = isEnd && (idx == candLen) && !fail;
    strobe.clrCount = isRestart;
    strobe.shift    = shiftEn;

    wrAddr = fill[ADDR_W-1:0];
    rdAddr = idx[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill <= '0;
    end else if (isRestart) begin
      fill <= '0;
    end else if (strobe.candWr) begin
      fill <= fill + ONE_I;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx  <= '0;
      fail <= 1'b0;
    end else if (isRestart || isEnd) begin
      idx  <= '0;
      fail <= 1'b0;
    end else if (searching) begin
      if (itemEq) begin
        idx <= idx + ONE_I;
      end else if (!storedGt) begin
        fail <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/support_dp.sv
module support_dp
  import support_pkg::*;
#(
  parameter int MAX_M  = 8,
  parameter int ITEM_W = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = (MAX_M > 1) ? $clog2(MAX_M) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        upKind,
  input  logic [ITEM_W-1:0] upData,
  input  logic [CNT_W-1:0]  shiftIn,
  output logic              itemEq,
  output logic              storedGt,
  output logic              dnValid,
  output logic [1:0]        dnKind,
  output logic [ITEM_W-1:0] dnData,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [ITEM_W-1:0] cand [MAX_M];
  logic [ITEM_W-1:0] storedItem;

  always_comb begin
    storedItem = cand[rdAddr];
    itemEq     = (storedItem == upData);
    storedGt   = (storedItem > upData);
  end

  for (genvar g = 0; g < MAX_M; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cand[g] <= '0;
      end else if (strobe.candWr && (wrAddr == ADDR_W'(g))) begin
        cand[g] <= upData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.shift) begin
      count <= shiftIn;
    end else if (strobe.clrCount) begin
      count <= '0;
    end else if (strobe.incCount && (count != CNT_MAX)) begin
      count <= count + ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dnValid <= 1'b0;
      dnKind  <= '0;
      dnData  <= '0;
    end else begin
      dnValid <= strobe.fwd;
      if (strobe.fwd) begin
        dnKind <= upKind;
        dnData <= upData;
      end
    end
  end

endmodule

// File: rtl/support_cell.sv
module support_cell
  import support_pkg::*;
#(
  parameter int MAX_M  = 8,
  parameter int ITEM_W = 16,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = $clog2(MAX_M + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  candLen,
  input  logic              upValid,
  input  logic [1:0]        upKind,
  input  logic [ITEM_W-1:0] upData,
  input  logic              shiftEn,
  input  logic [CNT_W-1:0]  shiftIn,
  output logic              dnValid,
  output logic [1:0]        dnKind,
  output logic [ITEM_W-1:0] dnData,
  output logic [CNT_W-1:0]  supportOut
);

  localparam int ADDR_W = (MAX_M > 1) ? $clog2(MAX_M) : 1;

  strobe_t           strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic              itemEq;
  logic              storedGt;

  support_ctl #(
    .MAX_M (MAX_M),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .candLen (candLen),
    .upValid (upValid),
    .upKind  (upKind),
    .shiftEn (shiftEn),
    .itemEq  (itemEq),
    .storedGt(storedGt),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr)
  );

  support_dp #(
    .MAX_M (MAX_M),
    .ITEM_W(ITEM_W),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .upKind  (upKind),
    .upData  (upData),
    .shiftIn (shiftIn),
    .itemEq  (itemEq),
    .storedGt(storedGt),
    .dnValid (dnValid),
    .dnKind  (dnKind),
    .dnData  (dnData),
    .count   (supportOut)
  );

endmodule

// File: rtl/support_cell_chk.sv
module support_cell_chk #(
  parameter int ITEM_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              upValid,
  input logic [1:0]        upKind,
  input logic [ITEM_W-1:0] upData,
  input logic              shiftEn,
  input logic [CNT_W-1:0]  shiftIn,
  input logic              dnValid,
  input logic [1:0]        dnKind,
  input logic [ITEM_W-1:0] dnData,
  input logic [CNT_W-1:0]  supportOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  // R4
  fwd_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upKind != 2'd2) |=> (dnValid && dnKind == $past(upKind) && dnData == $past(upData)));

  // R4
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !upValid |=> !dnValid);

  // R8
  item_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upKind == 2'd0 && !shiftEn) |=> $stable(supportOut));

  // R8
  end_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upKind == 2'd1 && !shiftEn) |=>
      (supportOut == $past(supportOut) || supportOut == $past(supportOut) + ONE_C));

  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upKind == 2'd1 && !shiftEn && supportOut == CNT_MAX) |=> (supportOut == CNT_MAX));

  // R10
  shift_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> (supportOut == $past(shiftIn)));

  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upKind == 2'd3 && !shiftEn) |=> (supportOut == '0));

endmodule

bind support_cell support_cell_chk #(
  .ITEM_W(ITEM_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .upValid   (upValid),
  .upKind    (upKind),
  .upData    (upData),
  .shiftEn   (shiftEn),
  .shiftIn   (shiftIn),
  .dnValid   (dnValid),
  .dnKind    (dnKind),
  .dnData    (dnData),
  .supportOut(supportOut)
);

// File: tb/support_cell_bench.sv
module support_cell_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_M  = 8;
  localparam int ITEM_W = 16;
  localparam int CNT_W  = 32;
  localparam int IDX_W  = $clog2(MAX_M + 1);
  localparam int NVEC   = 8;
  localparam int MAXT   = 6;

  // transactions against candidate {3,7,9}
  localparam logic [ITEM_W-1:0] TX_ITEM [NVEC][MAXT] = '{
    '{16'd3, 16'd7, 16'd9, 16'd0, 16'd0, 16'd0},
    '{16'd1, 16'd3, 16'd5, 16'd7, 16'd9, 16'd12},
    '{16'd3, 16'd7, 16'd0, 16'd0, 16'd0, 16'd0},
    '{16'd3, 16'd8, 16'd9, 16'd0, 16'd0, 16'd0},
    '{16'd2, 16'd4, 16'd7, 16'd9, 16'd0, 16'd0},
    '{16'd7, 16'd9, 16'd0, 16'd0, 16'd0, 16'd0},
    '{16'd3, 16'd5, 16'd7, 16'd9, 16'd0, 16'd0},
    '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}
  };
  localparam int TX_LEN [NVEC] = '{3, 6, 2, 3, 4, 2, 4, 0};
  localparam int TX_EXP [NVEC] = '{1, 2, 2, 2, 2, 2, 3, 3};
  localparam string TX_REQ [NVEC] = '{"R7", "R5", "R7", "R6", "R6", "R6", "R5", "R7"};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [IDX_W-1:0]  candLen = IDX_W'(3);
  logic              upValid = 1'b0;
  logic [1:0]        upKind = 2'd0;
  logic [ITEM_W-1:0] upData = '0;
  logic              shiftEn = 1'b0;
  logic [CNT_W-1:0]  shiftIn = '0;
  logic              dnValid;
  logic [1:0]        dnKind;
  logic [ITEM_W-1:0] dnData;
  logic [CNT_W-1:0]  supportOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  support_cell #(
    .MAX_M (MAX_M),
    .ITEM_W(ITEM_W),
    .CNT_W (CNT_W)
  ) u_support_cell (
    .clk       (clk),
    .rstN      (rstN),
    .candLen   (candLen),
    .upValid   (upValid),
    .upKind    (upKind),
    .upData    (upData),
    .shiftEn   (shiftEn),
    .shiftIn   (shiftIn),
    .dnValid   (dnValid),
    .dnKind    (dnKind),
    .dnData    (dnData),
    .supportOut(supportOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one word for one cycle; returns at the next falling edge,
  // where the forwarded copy and the count update are visible
  task automatic sendWord(input logic [1:0] kind, input logic [ITEM_W-1:0] data);
    upValid = 1'b1;
    upKind  = kind;
    upData  = data;
    @(negedge clk);
    upValid = 1'b0;
  endtask

  task automatic shiftWord(input logic [CNT_W-1:0] val);
    shiftEn = 1'b1;
    shiftIn = val;
    @(negedge clk);
    shiftEn = 1'b0;
  endtask

  task automatic sendTx(input logic [ITEM_W-1:0] a, input logic [ITEM_W-1:0] b,
                        input int n);
    if (n > 0) sendWord(2'd0, a);
    if (n > 1) sendWord(2'd0, b);
    sendWord(2'd1, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", supportOut, 0);
    chk("R1 dnValid in reset", 32'(dnValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", supportOut, 0);

    // load candidate {3,7,9}, m = 3
    sendWord(2'd3, '0);
    chk("R2 restart forwarded", {31'(dnKind), dnValid}, {31'd3, 1'b1});
    sendWord(2'd2, 16'd3);
    chk("R3 stored load not forwarded", 32'(dnValid), 0);
    sendWord(2'd2, 16'd7);
    sendWord(2'd2, 16'd9);
    chk("R3 last stored load not forwarded", 32'(dnValid), 0);
    sendWord(2'd2, 16'd11);
    chk("R3 extra load forwarded", {15'(dnData), 1'(dnValid), 16'(dnKind)},
        {15'd11, 1'b1, 16'd2});
    @(negedge clk);
    chk("R4 idle gap", 32'(dnValid), 0);

    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < TX_LEN[v]; k++) begin
        sendWord(2'd0, TX_ITEM[v][k]);
        if (k == 0) chk("R4 item forwarded", {14'(dnData), 2'(dnKind), 16'(dnValid)},
                        {14'(TX_ITEM[v][0]), 2'd0, 16'd1});
        if (k == TX_LEN[v] - 1) chk("R8 item leaves count", supportOut, 32'(TX_EXP[v] - ((v > 0) ? TX_EXP[v] - TX_EXP[v-1] : TX_EXP[v])));
      end
      sendWord(2'd1, '0);
      chk(TX_REQ[v], supportOut, 32'(TX_EXP[v]));
    end

    // R10: shift a near-max value in, then R9 saturation
    shiftWord(32'hFFFF_FFFE);
    chk("R10 shift load", supportOut, 32'hFFFF_FFFE);
    sendTx(16'd3, 16'd7, 2);
    chk("R7 short transaction no count", supportOut, 32'hFFFF_FFFE);
    sendWord(2'd0, 16'd3); sendWord(2'd0, 16'd7); sendWord(2'd0, 16'd9); sendWord(2'd1, '0);
    chk("R9 reach max", supportOut, 32'hFFFF_FFFF);
    sendWord(2'd0, 16'd3); sendWord(2'd0, 16'd7); sendWord(2'd0, 16'd9); sendWord(2'd1, '0);
    chk("R9 saturated", supportOut, 32'hFFFF_FFFF);

    // R10: shift takes precedence over a matching end word
    sendWord(2'd0, 16'd3); sendWord(2'd0, 16'd7); sendWord(2'd0, 16'd9);
    shiftEn = 1'b1; shiftIn = 32'd5;
    sendWord(2'd1, '0);
    shiftEn = 1'b0;
    chk("R10 shift wins over end", supportOut, 32'd5);

    // R2: restart clears, reload with m = 1
    candLen = IDX_W'(1);
    sendWord(2'd3, '0);
    chk("R2 restart clears count", supportOut, 0);
    sendWord(2'd2, 16'd4);
    chk("R3 single load stored", 32'(dnValid), 0);
    sendTx(16'd1, 16'd4, 2);
    chk("R5 m=1 match", supportOut, 1);
    sendTx(16'd5, 16'd0, 1);
    chk("R6 m=1 overshoot", supportOut, 1);
    sendTx(16'd4, 16'd0, 1);
    chk("R7 index cleared between transactions", supportOut, 2);

    // R1: mid-run reset
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset clears count", supportOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule